// File: doc/BRIEF.md
# Parallel Prefix Carry Adder

This block adds two N-bit operands and a single carry-in bit, and returns the N-bit sum and the carry-out. It contains no storage: the result follows the inputs through combinational logic only. The carries are not rippled from bit to bit. Each column first forms a bit-level generate term (both operand bits set) and a propagate term (either operand bit set). A tree of prefix cells then merges these terms into group terms whose spans double at every level, so the tree is log2(N) levels deep.

The carry-in is handled as an extra column that sits below bit 0. Its generate term equals the carry-in and its propagate term is zero. Because of this, every prefix that the tree resolves already includes the carry-in, and no separate carry-in stage is needed. The carry into a column is the group generate of the span from the column below it down to the carry-in column. Each sum bit is the XOR of the two operand bits and that carry. The carry-out takes one more merge, of the top column with the prefix below it.

The width N is a parameter. It must be a power of two and at least 2. One description covers every legal width.

Top module: `pfx_adder`

## Requirements
- R1: For every operand pair and carry-in, {cout_o, sum_o} equals the arithmetic value a_i + b_i + cin_i, with cout_o holding weight 2^N.
- R2: With both operands zero, sum_o equals the carry-in (value 1 when cin_i = 1, otherwise 0) and cout_o is 0.
- R3: All-ones plus one (a_i all ones, b_i = 1, cin_i = 0) gives sum_o = 0 and cout_o = 1, and so does a_i all ones, b_i = 0, cin_i = 1.
- R4: Alternating operands (a_i = 0101...01, b_i = 1010...10) give an all-ones sum and cout_o = 0 when cin_i = 0. With cin_i = 1 they give sum_o = 0 and cout_o = 1, the carry passing through every column.
- R5: When no column generates and every column propagates, cout_o equals cin_i.
- R6: When bit N-1 of both operands is 1, cout_o is 1 whatever the lower bits are.
- R7: The same description gives correct results for a small width (N = 4), checked over all 512 input combinations.
- R8: Both operands all ones with cin_i = 1 give sum_o all ones and cout_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum bits |
| cout_o | output | 1 | Carry out of bit N-1 |

## Verification
The assertions assume that every operand and carry-in bit is a known 0 or 1. Each check is guarded so that it is skipped while any input is still unknown. The bench drives every input bit to a defined value from the first cycle and never leaves a bit undriven, so the guard only matters before the first stimulus is applied. Expected sums are formed in the bench by plain wide arithmetic. The bench covers the full input space of a 4-bit instance and, on the 32-bit instance, the carry-chain corners and random operands.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    // Generate/propagate pair of one column or of a span of columns.
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Merge an upper span with the adjacent span just below it.
    function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/pfx_colgen.sv
module pfx_colgen #(
    parameter int N = 32
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] col_g_o,
    output logic [N-1:0] col_p_o
);
    // One bit-level term pair per column.
    for (genvar c = 0; c < N; c++) begin : g_col
        assign col_g_o[c] = a_i[c] & b_i[c];
        assign col_p_o[c] = a_i[c] | b_i[c];
    end
endmodule

// File: rtl/pfx_tree.sv
module pfx_tree
    import pfx_pkg::*;
#(
    parameter int N = 32
) (
    // Slot 0 is the carry-in column; slot k is column k-1.
    input  logic [N-1:0] g_i,
    input  logic [N-1:0] p_i,
    output logic [N-1:0] g_pre_o
);
    localparam int L = $clog2(N);

    logic [N-1:0] g_lv [L+1];
    logic [N-1:0] p_lv [L+1];

    assign g_lv[0] = g_i;
    assign p_lv[0] = p_i;

    // Level l: a slot whose bit l is set extends its span with the
    // fully resolved prefix of the slot just below its 2^l block.
    for (genvar l = 0; l < L; l++) begin : g_lvl
        for (genvar k = 0; k < N; k++) begin : g_slot
            if (((k >> l) & 1) == 1) begin : g_cell
                localparam int PART = ((k >> l) << l) - 1;
                gp_t merged;
                assign merged = gp_merge('{g: g_lv[l][k],    p: p_lv[l][k]},
                                         '{g: g_lv[l][PART], p: p_lv[l][PART]});
                assign g_lv[l+1][k] = merged.g;
                assign p_lv[l+1][k] = merged.p;
            end else begin : g_pass
                assign g_lv[l+1][k] = g_lv[l][k];
                assign p_lv[l+1][k] = p_lv[l][k];
            end
        end
    end

    assign g_pre_o = g_lv[L];

    // Every resolved span reaches the carry-in column, whose propagate
    // input is zero, so no final span may claim to propagate.
    always_comb begin
        if (!$isunknown(p_i)) begin
            AST_SPAN_CLOSED: assert (p_lv[L] == '0); // R1
        end
    end
endmodule

// File: rtl/pfx_sumgen.sv
module pfx_sumgen #(
    parameter int N = 32
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic [N-1:0] carry_i,
    output logic [N-1:0] sum_o
);
    for (genvar c = 0; c < N; c++) begin : g_bit
        assign sum_o[c] = a_i[c] ^ b_i[c] ^ carry_i[c];
    end
endmodule

// File: rtl/pfx_adder.sv
module pfx_adder #(
    parameter int N = 32
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         cin_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o
);
    logic [N-1:0] col_g, col_p;
    logic [N-1:0] slot_g, slot_p;
    logic [N-1:0] carry;

    pfx_colgen #(.N(N)) i_colgen (
        .a_i    (a_i),
        .b_i    (b_i),
        .col_g_o(col_g),
        .col_p_o(col_p)
    );

    // Carry-in enters as the lowest slot: generate = cin, propagate = 0.
    assign slot_g = {col_g[N-2:0], cin_i};
    assign slot_p = {col_p[N-2:0], 1'b0};

    pfx_tree #(.N(N)) i_tree (
        .g_i    (slot_g),
        .p_i    (slot_p),
        .g_pre_o(carry)
    );

    pfx_sumgen #(.N(N)) i_sumgen (
        .a_i    (a_i),
        .b_i    (b_i),
        .carry_i(carry),
        .sum_o  (sum_o)
    );

    // One extra merge folds the top column onto the full prefix.
    assign cout_o = col_g[N-1] | (col_p[N-1] & carry[N-1]);

    logic [N:0] ref_sum;
    assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i};

    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i})) begin
            AST_SUM_MATCH: assert ({cout_o, sum_o} == ref_sum); // R1
            if (a_i == '0 && b_i == '0) begin
                AST_ZERO_OPERANDS: assert (sum_o == {{(N-1){1'b0}}, cin_i} && !cout_o); // R2
            end
            if ((a_i & b_i) == '0 && (a_i | b_i) == '1) begin
                AST_FULL_PROPAGATE: assert (cout_o == cin_i); // R5
            end
            if (a_i[N-1] && b_i[N-1]) begin
                AST_TOP_GENERATE: assert (cout_o); // R6
            end
        end
    end
endmodule

// File: tb/test_pfx_adder.sv
module test_pfx_adder;
    localparam int  CLK_PERIOD = 10;
    localparam int  NW = 32;
    localparam int  NS = 4;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NW-1:0] a_w, b_w, s_w;
    logic          cin_w, cout_w;
    logic [NS-1:0] a_s, b_s, s_s;
    logic          cin_s, cout_s;

    pfx_adder #(.N(NW)) i_pfx_adder (
        .a_i(a_w), .b_i(b_w), .cin_i(cin_w), .sum_o(s_w), .cout_o(cout_w)
    );

    pfx_adder #(.N(NS)) i_pfx_adder_small (
        .a_i(a_s), .b_i(b_s), .cin_i(cin_s), .sum_o(s_s), .cout_o(cout_s)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    // Drive the wide instance, then compare at the falling edge.
    task automatic wide(input string tag, input logic [NW-1:0] a, input logic [NW-1:0] b,
                        input logic cin);
        logic [NW:0] e;
        @(posedge clk);
        a_w = a; b_w = b; cin_w = cin;
        e = {1'b0, a} + {1'b0, b} + {{NW{1'b0}}, cin};
        @(negedge clk);
        check(tag, {31'd0, cout_w, s_w}, {31'd0, e});
    endtask

    initial begin
        a_w = '0; b_w = '0; cin_w = 1'b0;
        a_s = '0; b_s = '0; cin_s = 1'b0;
        @(negedge clk);
        check("R1 idle zero", {31'd0, cout_w, s_w}, 64'd0);

        // R2: zero operands, carry-in only
        wide("R2 zero cin0", '0, '0, 1'b0);
        wide("R2 zero cin1", '0, '0, 1'b1);
        check("R2 sum is one", {32'd0, s_w}, 64'd1);

        // R3: all ones plus one, two ways
        wide("R3 ones+1", '1, 32'd1, 1'b0);
        check("R3 wrap", {31'd0, cout_w, s_w}, 64'h1_0000_0000);
        wide("R3 ones+cin", '1, '0, 1'b1);
        check("R3 wrap cin", {31'd0, cout_w, s_w}, 64'h1_0000_0000);

        // R4: alternating patterns
        wide("R4 alt cin0", 32'h5555_5555, 32'hAAAA_AAAA, 1'b0);
        check("R4 all ones", {31'd0, cout_w, s_w}, 64'h0_FFFF_FFFF);
        wide("R4 alt cin1", 32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
        check("R4 chain", {31'd0, cout_w, s_w}, 64'h1_0000_0000);
        wide("R4 alt swap", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
        wide("R4 alt same", 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0);

        // R5: full propagate, no generate -> cout equals cin
        wide("R5 prop", 32'h0F0F_1234, ~32'h0F0F_1234, 1'b0);
        check("R5 cout0", {63'd0, cout_w}, 64'd0);
        wide("R5 prop cin", 32'h0F0F_1234, ~32'h0F0F_1234, 1'b1);
        check("R5 cout1", {63'd0, cout_w}, 64'd1);

        // R6: top column generates
        wide("R6 top gen", 32'h8000_0000, 32'h8000_0000, 1'b0);
        check("R6 cout", {63'd0, cout_w}, 64'd1);

        // R8: largest operands with carry-in
        wide("R8 max", '1, '1, 1'b1);
        check("R8 value", {31'd0, cout_w, s_w}, 64'h1_FFFF_FFFF);

        // R1: random operands
        for (int i = 0; i < 2000; i++) begin
            wide("R1 random", $urandom, $urandom, 1'($urandom));
        end

        // R7: exhaustive sweep of the 4-bit instance
        for (int v = 0; v < 512; v++) begin
            @(posedge clk);
            a_s = 4'(v); b_s = 4'(v >> 4); cin_s = 1'(v >> 8);
            @(negedge clk);
            check("R7 small", {59'd0, cout_s, s_s},
                  64'((v & 15) + ((v >> 4) & 15) + ((v >> 8) & 1)));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog got=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule